// File: doc/BRIEF.md
# DAC Code Staging and Update Controller

This block is the register-side front end of a 12-bit voltage converter. A host sees three byte-wide locations on a simple write/read bus: a control byte, a low data byte and a high data byte. The 12-bit converter code is assembled from the two data bytes. The control byte selects how the code is split between them. Whatever bits the chosen split leaves unused are ignored.

The assembled code moves into the converter input register only on an update event. In the default mode that event is a write to the high byte. In the three timer modes it is the first clock edge on which the selected overflow pulse is high. Writes that arrive before the event are only staged. The enable bit drives the converter enable line, and its inverse requests a high-impedance output pin. Code 000h is the lowest output and FFFh is full scale.

Top module: `dac_code_ctrl`

## Requirements
- R1: After reset, the converter code is 000h, `dac_en` is 0, `dac_hiz` is 1, and reads of addresses 0, 1 and 2 all return 00h.
- R2: A write to the control byte (address 0) stores bits 7 and 4:0. Bits 6:5 always read as 0, so a write of FFh reads back as 9Fh.
- R3: One cycle after a control write, `dac_en` equals the written bit 7 and `dac_hiz` is its inverse.
- R4: A write to the low byte (address 1) never changes the converter code by itself.
- R5: In update mode 00 (control bits 4:3), a write to the high byte (address 2) loads the code on that clock edge. The code is assembled from the written byte and the stored low byte.
- R6: Alignment (control bits 2:0) 000, 001, 010 and 011 take the top 4, 5, 6 or 7 code bits from high[3:0], high[4:0], high[5:0] or high[6:0]. The remaining 8, 7, 6 or 5 bits come from low[7:0], low[7:1], low[7:2] or low[7:3].
- R7: Any alignment value 1xx takes the top 8 code bits from high[7:0] and the bottom 4 from low[7:4].
- R8: In update modes 01, 10 and 11, a high-byte write is only staged and leaves the code unchanged.
- R9: Mode 01 loads the staged word on a Timer 3 overflow (`ovf_t3`), mode 10 on `ovf_t4`, and mode 11 on `ovf_t2`. Pulses from the other timers leave the code unchanged, and mode 00 ignores all three pulses.
- R10: Reads of the low and high bytes return the full 8-bit values last written, including bits the alignment ignores.
- R11: The alignment in effect at the update event is the one applied, even if it changed after the data bytes were written.
- R12: Address 3 reads as 00h, and writes to it change no register and not the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 low, 2 high, 3 unused |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ovf_t2 | input | 1 | Timer 2 overflow pulse |
| ovf_t3 | input | 1 | Timer 3 overflow pulse |
| ovf_t4 | input | 1 | Timer 4 overflow pulse |
| dac_code | output | 12 | Code applied to the converter input |
| dac_en | output | 1 | Converter enable |
| dac_hiz | output | 1 | Request to place the converter output pin in high impedance |

## Verification
A corrupted staged byte stays hidden until the next update event, and then shows up as a wrong `dac_code` on that very edge. For this reason, every stored byte is also checked through the read port right after it is written. A wrong update-mode decode shows as a code that changes one edge early, on an unselected pulse, or on a staged high write. A code that stays frozen on the selected pulse points to the same fault. The bench samples the code after each single event so that any such slip is caught on the cycle it happens. Alignment errors appear as misplaced bit fields in the loaded code, so the test patterns use asymmetric bytes that tell neighbouring formats apart.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int ADDR_W = 2;
  localparam int FMT_W  = 3;
  localparam int MODE_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_LOW  = 2'd1,
    A_HIGH = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [MODE_W-1:0] {
    UPD_ON_HIGH = 2'b00,
    UPD_TMR3    = 2'b01,
    UPD_TMR4    = 2'b10,
    UPD_TMR2    = 2'b11
  } upd_mode_e;

  typedef struct packed {
    logic             en;
    logic [MODE_W-1:0] mode;
    logic [FMT_W-1:0]  fmt;
  } ctrl_t;
endpackage

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output ctrl_t             ctrl_q,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              hi_wr
);
  localparam int CTRL_PAD = BYTE_W - 1 - MODE_W - FMT_W;

  ctrl_t             ctrl_d;
  logic [BYTE_W-1:0] lo_d, hi_d;
  logic              ctrl_wr, lo_wr;

  always_comb begin
    ctrl_wr = wr_en && (addr == A_CTRL);
    lo_wr   = wr_en && (addr == A_LOW);
    hi_wr   = wr_en && (addr == A_HIGH);
    ctrl_d  = ctrl_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    if (ctrl_wr) begin
      ctrl_d.en   = wdata[BYTE_W-1];
      ctrl_d.mode = wdata[FMT_W +: MODE_W];
      ctrl_d.fmt  = wdata[FMT_W-1:0];
    end
    if (lo_wr) lo_d = wdata;
    if (hi_wr) hi_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_d;
      if (lo_wr)   lo_q   <= lo_d;
      if (hi_wr)   hi_q   <= hi_d;
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = {ctrl_q.en, {CTRL_PAD{1'b0}}, ctrl_q.mode, ctrl_q.fmt};
      A_LOW:   rdata = lo_q;
      A_HIGH:  rdata = hi_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dacfe_align.sv
module dacfe_align
  import dacfe_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 12
) (
  input  logic [FMT_W-1:0]  fmt,
  input  logic [BYTE_W-1:0] hi,
  input  logic [BYTE_W-1:0] lo,
  output logic [CODE_W-1:0] word
);
  localparam int HI_MIN = CODE_W - BYTE_W;
  localparam int N_FMT  = BYTE_W - HI_MIN + 1;
  localparam int SEL_W  = (N_FMT > 1) ? $clog2(N_FMT) : 1;

  logic [CODE_W-1:0] cand [N_FMT];
  logic [SEL_W-1:0]  sel;

  for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
    localparam int HB = HI_MIN + g;
    localparam int LB = CODE_W - HB;
    assign cand[g] = {hi[HB-1:0], lo[BYTE_W-1 -: LB]};
  end

  always_comb begin
    if (int'(fmt) >= N_FMT - 1) sel = SEL_W'(N_FMT - 1);
    else                        sel = fmt[SEL_W-1:0];
    word = cand[sel];
  end
endmodule

// File: rtl/dacfe_sched.sv
module dacfe_sched
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  upd_mode_e         mode,
  input  logic              hi_wr,
  input  logic              ovf_t2,
  input  logic              ovf_t3,
  input  logic              ovf_t4,
  input  logic [CODE_W-1:0] demand_word,
  input  logic [CODE_W-1:0] staged_word,
  output logic [CODE_W-1:0] code_q
);
  logic              load;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    unique case (mode)
      UPD_ON_HIGH: begin load = hi_wr;  code_d = demand_word; end
      UPD_TMR3:    begin load = ovf_t3; code_d = staged_word; end
      UPD_TMR4:    begin load = ovf_t4; code_d = staged_word; end
      default:     begin load = ovf_t2; code_d = staged_word; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= '0;
    else if (load) code_q <= code_d;
  end
endmodule

// File: rtl/dac_code_ctrl.sv
module dac_code_ctrl
  import dacfe_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              ovf_t2,
  input  logic              ovf_t3,
  input  logic              ovf_t4,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_en,
  output logic              dac_hiz
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              hi_wr;
  logic [CODE_W-1:0] demand_word, staged_word;
  upd_mode_e         upd_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  dacfe_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ctrl_q(ctrl_q), .lo_q(lo_q),
    .hi_q(hi_q), .hi_wr(hi_wr)
  );

  dacfe_align #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) u_align_demand (
    .fmt(ctrl_q.fmt), .hi(wdata), .lo(lo_q), .word(demand_word)
  );

  dacfe_align #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) u_align_staged (
    .fmt(ctrl_q.fmt), .hi(hi_q), .lo(lo_q), .word(staged_word)
  );

  assign upd_mode = upd_mode_e'(ctrl_q.mode);

  dacfe_sched #(.CODE_W(CODE_W)) u_sched (
    .clk(clk), .rst_n(rst_sync_n), .mode(upd_mode), .hi_wr(hi_wr),
    .ovf_t2(ovf_t2), .ovf_t3(ovf_t3), .ovf_t4(ovf_t4),
    .demand_word(demand_word), .staged_word(staged_word), .code_q(dac_code)
  );

  assign dac_en  = ctrl_q.en;
  assign dac_hiz = ~ctrl_q.en;
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [BYTE_W-1:0] wdata,
  input logic [BYTE_W-1:0] rdata,
  input logic              ovf_t2,
  input logic              ovf_t3,
  input logic              ovf_t4,
  input logic [1:0]        mode,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_en
);
  assert_ctrl_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> (dac_en == $past(wdata[BYTE_W-1])));

  assert_low_staged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && mode == 2'b00) |=> $stable(dac_code));

  assert_timer_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && !ovf_t2 && !ovf_t3 && !ovf_t4) |=> $stable(dac_code));

  assert_demand_ignores_timers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !(wr_en && addr == 2'd2)) |=> $stable(dac_code));

  assert_ctrl_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> (rdata[6:5] == 2'b00));

  assert_unused_addr_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3) |-> (rdata == '0));
endmodule

bind dac_code_ctrl dacfe_chk #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .ovf_t2(ovf_t2), .ovf_t3(ovf_t3), .ovf_t4(ovf_t4),
  .mode(ctrl_q.mode), .dac_code(dac_code), .dac_en(dac_en)
);

// File: tb/test_dac_code_ctrl.sv
`timescale 1ns/1ps
module test_dac_code_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        ovf_t2, ovf_t3, ovf_t4;
  logic [11:0] dac_code;
  logic        dac_en, dac_hiz;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dac_code_ctrl i_dac_code_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ovf_t2(ovf_t2), .ovf_t3(ovf_t3), .ovf_t4(ovf_t4),
    .dac_code(dac_code), .dac_en(dac_en), .dac_hiz(dac_hiz)
  );

  // fmt[30:28], low[27:20], high[19:12], expected code[11:0]; mode 00, enabled
  localparam logic [30:0] VEC [9] = '{
    {3'd0, 8'hA5, 8'h3C, 12'hCA5},
    {3'd1, 8'h81, 8'hF3, 12'h9C0},
    {3'd2, 8'hFC, 8'h2A, 12'hABF},
    {3'd3, 8'h18, 8'hFF, 12'hFE3},
    {3'd4, 8'h5F, 8'h96, 12'h965},
    {3'd7, 8'hF0, 8'hFF, 12'hFFF},
    {3'd5, 8'h0F, 8'h00, 12'h000},
    {3'd0, 8'hFF, 8'hFF, 12'hFFF},
    {3'd6, 8'h9A, 8'h5C, 12'h5C9}
  };

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(bit t2, bit t3, bit t4);
    @(negedge clk);
    ovf_t2 = t2; ovf_t3 = t3; ovf_t4 = t4;
    @(negedge clk);
    ovf_t2 = 1'b0; ovf_t3 = 1'b0; ovf_t4 = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [11:0] prev;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    ovf_t2 = 1'b0; ovf_t3 = 1'b0; ovf_t4 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1", "code", dac_code, 12'h000);
    check("R1", "en", dac_en, 0);
    check("R1", "hiz", dac_hiz, 1);
    rd(2'd0, r); check("R1", "ctrl read", r, 8'h00);
    rd(2'd1, r); check("R1", "low read", r, 8'h00);
    rd(2'd2, r); check("R1", "high read", r, 8'h00);

    // R2/R3 control read-back and enable
    wr(2'd0, 8'hFF);
    check("R3", "en after set", dac_en, 1);
    check("R3", "hiz after set", dac_hiz, 0);
    rd(2'd0, r); check("R2", "ctrl unused bits", r, 8'h9F);
    wr(2'd0, 8'h00);
    check("R3", "en after clear", dac_en, 0);
    check("R3", "hiz after clear", dac_hiz, 1);

    // R4 R5 R6 R7 R10 table walk in mode 00
    foreach (VEC[i]) begin
      prev = dac_code;
      wr(2'd0, {5'b10000, VEC[i][30:28]});
      wr(2'd1, VEC[i][27:20]);
      check("R4", "low write staged", dac_code, prev);
      wr(2'd2, VEC[i][19:12]);
      check(VEC[i][30] ? "R7" : "R6", "aligned code (R5)", dac_code, VEC[i][11:0]);
      rd(2'd1, r); check("R10", "low read", r, VEC[i][27:20]);
      rd(2'd2, r); check("R10", "high read", r, VEC[i][19:12]);
    end
    // code is now 5C9

    // R12 unused address
    wr(2'd3, 8'hAA);
    rd(2'd3, r); check("R12", "addr3 read", r, 8'h00);
    rd(2'd0, r); check("R12", "ctrl after addr3 write", r, 8'h86);
    check("R12", "code after addr3 write", dac_code, 12'h5C9);

    // R8 R9 mode 01 (timer 3), alignment 1xx
    wr(2'd0, 8'h8C);
    wr(2'd1, 8'h30);
    wr(2'd2, 8'h12);
    check("R8", "high staged in mode 01", dac_code, 12'h5C9);
    pulse(1, 0, 0); check("R9", "mode 01 ignores t2", dac_code, 12'h5C9);
    pulse(0, 0, 1); check("R9", "mode 01 ignores t4", dac_code, 12'h5C9);
    pulse(0, 1, 0); check("R9", "mode 01 loads on t3", dac_code, 12'h123);

    // mode 10 (timer 4)
    wr(2'd0, 8'h94);
    wr(2'd2, 8'h45);
    check("R8", "high staged in mode 10", dac_code, 12'h123);
    pulse(1, 1, 0); check("R9", "mode 10 ignores t2/t3", dac_code, 12'h123);
    pulse(0, 0, 1); check("R9", "mode 10 loads on t4", dac_code, 12'h453);

    // mode 11 (timer 2)
    wr(2'd0, 8'h9C);
    wr(2'd2, 8'h67);
    check("R8", "high staged in mode 11", dac_code, 12'h453);
    pulse(0, 1, 1); check("R9", "mode 11 ignores t3/t4", dac_code, 12'h453);
    pulse(1, 0, 0); check("R9", "mode 11 loads on t2", dac_code, 12'h673);

    // R11 alignment changed after staging, applied at event
    wr(2'd0, 8'h98);
    pulse(1, 0, 0); check("R11", "format at event", dac_code, 12'h730);

    // R9 mode 00 ignores all timers
    wr(2'd0, 8'h80);
    pulse(1, 1, 1); check("R9", "mode 00 ignores timers", dac_code, 12'h730);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule